// File: doc/BRIEF.md
# I2C Slave Flow-Control State Machine

This block is the control unit of an I2C slave that sits between the bit-level byte engine, the receive and transmit FIFOs and the host. It follows the slave through seven states and publishes the current state as a 3-bit status code. When the receive FIFO fills or the transmit FIFO runs dry in the middle of a transfer, it stretches SCL. The stretch lasts no longer than a programmable timeout, and the host can read the remaining wait time while it runs.

If a stall is still unresolved when the timeout expires, the machine resolves it in one of two ways. On the receive side it forces a not-acknowledge and flushes the receive FIFO. On the transmit side it requests that the previously sent byte be sent again. Every ending of a transfer is recorded in a 3-bit recovery code. The FIFOs and the bit-level protocol are outside the block. The block sees only one-cycle event strobes and the FIFO level flags, and it answers with a hold level and one-cycle action strobes.

Top module: `i2cs_flow_ctrl`

## Requirements
- R1: After reset the status is 0 (Sleep), the recovery code is 0, the bus is released (`bus_off`=1), SCL is not held, the remaining wait is 0 and all action strobes are low.
- R2: With `ctl_enable`=1, Sleep moves to Standby (status 1) on the next clock. With `ctl_enable`=0, any state returns to Sleep on the next clock, and `bus_off` is 1 exactly while the status is 0.
- R3: In Standby, an address match with `addr_rw`=0 enters Receive (status 3) when `rx_full`=0. When `rx_full`=1 it pulses `force_nack` for one cycle and stays in Standby.
- R4: In Standby, an address match with `addr_rw`=1 sets `tx_irq_en`. It enters Transmit (status 2) when `tx_empty`=0, or Busy_Rec_Trm_T (status 6, SCL held) when `tx_empty`=1.
- R5: In Receive, `stop_det` without `rx_full` returns to Standby with recovery 0. `ctl_host_nack`=1 returns to Standby with a `force_nack` pulse. If the receive FIFO is not empty it also pulses `rx_flush` and sets recovery 1; otherwise it sets recovery 0 and gives no flush.
- R6: In Receive, `rx_full`=1 without `stop_det` enters Busy_Rec_Trm_R (status 5) with SCL held. While there, `rx_full` going to 0 returns to Receive and releases SCL.
- R7: When the receive timeout expires in status 5, the block releases SCL, pulses `force_nack` and `rx_flush`, enters Standby and sets recovery 3.
- R8: In Receive, `rx_full`=1 together with `stop_det` enters Busy_Rec_R (status 4) without holding SCL. There, a write match is answered with a `force_nack` pulse and the state is kept. A read match is handled as in Standby. `rx_full`=0 returns to Standby. Timeout expiry pulses `rx_flush`, enters Standby and sets recovery 2.
- R9: In Transmit, `mst_nack` returns to Standby, pulses `tx_flush` and clears `tx_irq_en`.
- R10: In Transmit, `byte_req` while `tx_empty`=1 enters Busy_Rec_Trm_T (status 6) with SCL held. There, `tx_empty` going to 0 returns to Transmit with recovery 0.
- R11: When the transmit timeout expires in status 6, the block releases SCL, pulses `dup_req`, returns to Transmit and sets recovery 4. A later empty-FIFO byte request stalls again.
- R12: On entry to a busy state (4, 5 or 6), `tmo_now` shows the programmed timeout (`rx_tmo` for 4 and 5, `tx_tmo` for 6) and then decrements by one each clock. Expiry acts on the clock after `tmo_now` reads 0, so a timeout of N keeps the state for N+1 cycles. `tmo_now` is 0 outside busy states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Host enable; 0 forces Sleep and releases the bus |
| ctl_host_nack | input | 1 | Host request to refuse further received bytes |
| addr_match | input | 1 | One-cycle strobe: own address recognised |
| addr_rw | input | 1 | Direction bit of the matched address (1 = master reads) |
| stop_det | input | 1 | One-cycle strobe: STOP condition seen |
| mst_nack | input | 1 | One-cycle strobe: master did not acknowledge a sent byte |
| byte_req | input | 1 | One-cycle strobe: master acknowledged and the next byte is needed |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_tmo | input | TMO_W | Receive-side wait limit in clocks |
| tx_tmo | input | TMO_W | Transmit-side wait limit in clocks |
| status | output | 3 | Current state code (0..6) |
| recover | output | 3 | Code of the last transfer ending (0..4) |
| tmo_now | output | TMO_W | Remaining wait clocks |
| scl_hold | output | 1 | Drive SCL low (clock stretch) |
| bus_off | output | 1 | Release SCL and SDA to high impedance |
| tx_irq_en | output | 1 | Transmit-side interrupt enable |
| force_nack | output | 1 | One-cycle strobe: answer with not-acknowledge |
| rx_flush | output | 1 | One-cycle strobe: reset the receive FIFO |
| tx_flush | output | 1 | One-cycle strobe: reset the transmit FIFO |
| dup_req | output | 1 | One-cycle strobe: resend the previously sent byte |

## Verification
A wrong state shows on `status` in the same sample that follows the deciding clock edge. It also shows as a mismatch on `scl_hold`, because only two codes may stretch. A timer that loads or counts wrongly shows on `tmo_now` on the first busy cycle, and it shows as an exit one cycle early or late. A wrong recovery choice shows on `recover` and on the flush and duplicate strobes in the same sample as the state change. The bench walks every stall to both of its exits.

// File: rtl/i2cs_flow_pkg.sv
package i2cs_flow_pkg;

   typedef enum logic [2:0] {
      FC_SLEEP      = 3'd0,
      FC_IDLE       = 3'd1,
      FC_SEND       = 3'd2,
      FC_RECV       = 3'd3,
      FC_DRAIN_RX   = 3'd4,
      FC_STALL_RX   = 3'd5,
      FC_STALL_TX   = 3'd6
   } fc_state_e;

   localparam logic [2:0] REC_CLEAN      = 3'd0;
   localparam logic [2:0] REC_HOST_ABORT = 3'd1;
   localparam logic [2:0] REC_DRAIN_LOST = 3'd2;
   localparam logic [2:0] REC_STALL_LOST = 3'd3;
   localparam logic [2:0] REC_REPEAT     = 3'd4;

   localparam int unsigned FC_NUM_PULSES = 4;

   typedef struct packed {
      logic nack;
      logic rx_flush;
      logic tx_flush;
      logic dup;
   } fc_pulse_t;

   function automatic logic fc_is_busy(fc_state_e s);
      return (s == FC_DRAIN_RX) || (s == FC_STALL_RX) || (s == FC_STALL_TX);
   endfunction

endpackage

// File: rtl/fc_wait_timer.sv
module fc_wait_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMO_W-1:0] load_val,
   input  logic             run,
   output logic [TMO_W-1:0] count,
   output logic             expired
);
   localparam logic [TMO_W-1:0] ONE = {{(TMO_W-1){1'b0}}, 1'b1};

   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign count   = cnt_q;
   assign expired = (cnt_q == '0);
endmodule

// File: rtl/fc_pulse_reg.sv
module fc_pulse_reg #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
         end
      end
   endgenerate
endmodule

// File: rtl/fc_fsm.sv
module fc_fsm
   import i2cs_flow_pkg::*;
#(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_enable,
   input  logic             ctl_host_nack,
   input  logic             addr_match,
   input  logic             addr_rw,
   input  logic             stop_det,
   input  logic             mst_nack,
   input  logic             byte_req,
   input  logic             rx_full,
   input  logic             rx_empty,
   input  logic             tx_empty,
   input  logic [TMO_W-1:0] rx_tmo,
   input  logic [TMO_W-1:0] tx_tmo,
   input  logic             tmr_expired,
   output fc_state_e        state,
   output logic [2:0]       recover,
   output logic             tx_irq_en,
   output logic             tmr_load,
   output logic [TMO_W-1:0] tmr_val,
   output logic             tmr_run,
   output fc_pulse_t        pulse_req
);
   fc_state_e  state_q, state_d;
   logic [2:0] rec_q, rec_d;
   logic       irq_q, irq_d;

   // read match: same handling from Standby and Busy_Rec_R
   task automatic take_read(output fc_state_e nx, output logic ld,
                            output logic [TMO_W-1:0] lv);
      if (tx_empty) begin
         nx = FC_STALL_TX;
         ld = 1'b1;
      end else begin
         nx = FC_SEND;
         ld = 1'b0;
      end
      lv = tx_tmo;
   endtask

   always_comb begin
      state_d   = state_q;
      rec_d     = rec_q;
      irq_d     = irq_q;
      pulse_req = '0;
      tmr_load  = 1'b0;
      tmr_val   = rx_tmo;

      if (!ctl_enable) begin
         state_d = FC_SLEEP;
      end else begin
         unique case (state_q)
            FC_SLEEP: state_d = FC_IDLE;

            FC_IDLE: begin
               if (addr_match && !addr_rw) begin
                  if (rx_full) pulse_req.nack = 1'b1;
                  else         state_d = FC_RECV;
               end else if (addr_match && addr_rw) begin
                  irq_d = 1'b1;
                  take_read(state_d, tmr_load, tmr_val);
               end
            end

            FC_RECV: begin
               if (ctl_host_nack) begin
                  state_d        = FC_IDLE;
                  pulse_req.nack = 1'b1;
                  if (!rx_empty) begin
                     pulse_req.rx_flush = 1'b1;
                     rec_d              = REC_HOST_ABORT;
                  end else begin
                     rec_d = REC_CLEAN;
                  end
               end else if (rx_full) begin
                  tmr_load = 1'b1;
                  tmr_val  = rx_tmo;
                  state_d  = stop_det ? FC_DRAIN_RX : FC_STALL_RX;
               end else if (stop_det) begin
                  state_d = FC_IDLE;
                  rec_d   = REC_CLEAN;
               end
            end

            FC_STALL_RX: begin
               if (!rx_full) begin
                  state_d = FC_RECV;
               end else if (tmr_expired) begin
                  state_d            = FC_IDLE;
                  pulse_req.nack     = 1'b1;
                  pulse_req.rx_flush = 1'b1;
                  rec_d              = REC_STALL_LOST;
               end
            end

            FC_DRAIN_RX: begin
               if (addr_match && !addr_rw) begin
                  pulse_req.nack = 1'b1;
               end else if (addr_match && addr_rw) begin
                  irq_d = 1'b1;
                  take_read(state_d, tmr_load, tmr_val);
               end else if (!rx_full) begin
                  state_d = FC_IDLE;
               end else if (tmr_expired) begin
                  state_d            = FC_IDLE;
                  pulse_req.rx_flush = 1'b1;
                  rec_d              = REC_DRAIN_LOST;
               end
            end

            FC_SEND: begin
               if (mst_nack) begin
                  state_d            = FC_IDLE;
                  pulse_req.tx_flush = 1'b1;
                  irq_d              = 1'b0;
               end else if (byte_req && tx_empty) begin
                  state_d  = FC_STALL_TX;
                  tmr_load = 1'b1;
                  tmr_val  = tx_tmo;
               end else if (stop_det) begin
                  state_d = FC_IDLE;
               end
            end

            FC_STALL_TX: begin
               if (!tx_empty) begin
                  state_d = FC_SEND;
                  rec_d   = REC_CLEAN;
               end else if (tmr_expired) begin
                  state_d       = FC_SEND;
                  pulse_req.dup = 1'b1;
                  rec_d         = REC_REPEAT;
               end
            end

            default: state_d = FC_SLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FC_SLEEP;
         rec_q   <= REC_CLEAN;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         rec_q   <= rec_d;
         irq_q   <= irq_d;
      end
   end

   assign tmr_run   = fc_is_busy(state_q) && (state_d == state_q);
   assign state     = state_q;
   assign recover   = rec_q;
   assign tx_irq_en = irq_q;
endmodule

// File: rtl/i2cs_flow_ctrl.sv
module i2cs_flow_ctrl
   import i2cs_flow_pkg::*;
#(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_enable,
   input  logic             ctl_host_nack,
   input  logic             addr_match,
   input  logic             addr_rw,
   input  logic             stop_det,
   input  logic             mst_nack,
   input  logic             byte_req,
   input  logic             rx_full,
   input  logic             rx_empty,
   input  logic             tx_empty,
   input  logic [TMO_W-1:0] rx_tmo,
   input  logic [TMO_W-1:0] tx_tmo,
   output logic [2:0]       status,
   output logic [2:0]       recover,
   output logic [TMO_W-1:0] tmo_now,
   output logic             scl_hold,
   output logic             bus_off,
   output logic             tx_irq_en,
   output logic             force_nack,
   output logic             rx_flush,
   output logic             tx_flush,
   output logic             dup_req
);
   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_width
         $error("TMO_W must lie in 2..32");
      end
   endgenerate

   fc_state_e              state;
   logic                   tmr_load, tmr_run, tmr_expired;
   logic [TMO_W-1:0]       tmr_val;
   fc_pulse_t              pulse_req, pulse_q;
   logic [FC_NUM_PULSES-1:0] pulse_vec;

   fc_fsm #(.TMO_W(TMO_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ctl_enable(ctl_enable), .ctl_host_nack(ctl_host_nack),
      .addr_match(addr_match), .addr_rw(addr_rw), .stop_det(stop_det),
      .mst_nack(mst_nack), .byte_req(byte_req),
      .rx_full(rx_full), .rx_empty(rx_empty), .tx_empty(tx_empty),
      .rx_tmo(rx_tmo), .tx_tmo(tx_tmo), .tmr_expired(tmr_expired),
      .state(state), .recover(recover), .tx_irq_en(tx_irq_en),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run),
      .pulse_req(pulse_req)
   );

   fc_wait_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load(tmr_load), .load_val(tmr_val), .run(tmr_run),
      .count(tmo_now), .expired(tmr_expired)
   );

   fc_pulse_reg #(.N(FC_NUM_PULSES)) u_pulses (
      .clk(clk), .rst_n(rst_n), .d(pulse_req), .q(pulse_vec)
   );

   assign pulse_q    = fc_pulse_t'(pulse_vec);
   assign force_nack = pulse_q.nack;
   assign rx_flush   = pulse_q.rx_flush;
   assign tx_flush   = pulse_q.tx_flush;
   assign dup_req    = pulse_q.dup;

   assign status   = state;
   assign bus_off  = (state == FC_SLEEP);
   assign scl_hold = (state == FC_STALL_RX) || (state == FC_STALL_TX);
endmodule

// File: rtl/i2cs_flow_ctrl_chk.sv
module i2cs_flow_ctrl_chk #(
   parameter int unsigned TMO_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_enable,
   input logic             addr_match,
   input logic             addr_rw,
   input logic [2:0]       status,
   input logic [TMO_W-1:0] tmo_now,
   input logic             scl_hold,
   input logic             tx_irq_en,
   input logic             rx_flush,
   input logic             tx_flush,
   input logic             dup_req
);
   // R2
   sleep_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |=> status == 3'd0);

   // R6
   hold_only_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> (status == 3'd5 || status == 3'd6));

   // R4
   read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_enable && addr_match && addr_rw && status == 3'd1)
      |=> (status == 3'd2 || status == 3'd6) && tx_irq_en);

   // R11
   dup_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dup_req |-> ($past(status) == 3'd6 && status == 3'd2));

   // R7
   rx_flush_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |-> ($past(status) == 3'd3 || $past(status) == 3'd4 ||
                    $past(status) == 3'd5));

   // R9
   tx_flush_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |-> !tx_irq_en);

   // R12
   countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status >= 3'd4 && status <= 3'd6 && status == $past(status) &&
       $past(tmo_now) != '0) |-> tmo_now == $past(tmo_now) - 1'b1);

   // R12
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status < 3'd4) |-> tmo_now == '0);
endmodule

bind i2cs_flow_ctrl i2cs_flow_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
   .addr_match(addr_match), .addr_rw(addr_rw), .status(status),
   .tmo_now(tmo_now), .scl_hold(scl_hold), .tx_irq_en(tx_irq_en),
   .rx_flush(rx_flush), .tx_flush(tx_flush), .dup_req(dup_req)
);

// File: tb/tb_i2cs_flow_ctrl.sv
module tb_i2cs_flow_ctrl;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic ctl_enable, ctl_host_nack, addr_match, addr_rw, stop_det;
   logic mst_nack, byte_req, rx_full, rx_empty, tx_empty;
   logic [TW-1:0] rx_tmo, tx_tmo, tmo_now;
   logic [2:0] status, recover;
   logic scl_hold, bus_off, tx_irq_en, force_nack, rx_flush, tx_flush, dup_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   i2cs_flow_ctrl #(.TMO_W(TW)) dut (.*);

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ctl_enable = 0; ctl_host_nack = 0; addr_match = 0; addr_rw = 0;
      stop_det = 0; mst_nack = 0; byte_req = 0;
      rx_full = 0; rx_empty = 1; tx_empty = 0;
      rx_tmo = 16'd3; tx_tmo = 16'd2;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic go_idle();
      ctl_enable = 1; step();
   endtask

   task automatic match(logic rw);
      addr_match = 1; addr_rw = rw; step(); addr_match = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "status", status, 0);
      chk("R1", "recover", recover, 0);
      chk("R1", "bus_off", bus_off, 1);
      chk("R1", "scl_hold", scl_hold, 0);
      chk("R1", "tmo_now", tmo_now, 0);
      chk("R1", "strobes", {force_nack, rx_flush, tx_flush, dup_req}, 0);
   endtask

   task automatic t_enable();
      do_reset();
      go_idle();
      chk("R2", "standby", status, 1);
      chk("R2", "bus_off", bus_off, 0);
      match(1'b1);
      ctl_enable = 0; step();
      chk("R2", "sleep from transmit", status, 0);
      chk("R2", "bus_off", bus_off, 1);
   endtask

   task automatic t_write_match();
      do_reset(); go_idle();
      match(1'b0);
      chk("R3", "receive", status, 3);
      chk("R3", "no nack", force_nack, 0);
      do_reset(); go_idle();
      rx_full = 1; match(1'b0);
      chk("R3", "refused stays standby", status, 1);
      chk("R3", "nack pulse", force_nack, 1);
      step();
      chk("R3", "nack one cycle", force_nack, 0);
   endtask

   task automatic t_receive_end();
      do_reset(); go_idle(); match(1'b0);
      stop_det = 1; step(); stop_det = 0;
      chk("R5", "stop to standby", status, 1);
      chk("R5", "stop recover", recover, 0);
      match(1'b0);
      rx_empty = 0; ctl_host_nack = 1; step(); ctl_host_nack = 0;
      chk("R5", "host nack standby", status, 1);
      chk("R5", "host nack pulse", force_nack, 1);
      chk("R5", "flush nonempty", rx_flush, 1);
      chk("R5", "recover 1", recover, 1);
      match(1'b0);
      rx_empty = 1; ctl_host_nack = 1; step(); ctl_host_nack = 0;
      chk("R5", "flush empty", rx_flush, 0);
      chk("R5", "recover 0 when empty", recover, 0);
   endtask

   task automatic t_rx_stall();
      do_reset(); go_idle(); match(1'b0);
      rx_full = 1; step();
      chk("R6", "stall rx", status, 5);
      chk("R6", "hold", scl_hold, 1);
      chk("R12", "loaded", tmo_now, 3);
      rx_full = 0; step();
      chk("R6", "back to receive", status, 3);
      chk("R6", "hold released", scl_hold, 0);
      chk("R12", "zero outside", tmo_now, 0);
      rx_full = 1; step();
      for (int k = 2; k >= 0; k--) begin
         step();
         chk("R12", "countdown", tmo_now, k);
         chk("R7", "still stalled", status, 5);
      end
      step();
      chk("R7", "standby", status, 1);
      chk("R7", "recover 3", recover, 3);
      chk("R7", "nack", force_nack, 1);
      chk("R7", "flush", rx_flush, 1);
      chk("R7", "hold released", scl_hold, 0);
   endtask

   task automatic t_drain();
      do_reset(); go_idle(); match(1'b0);
      rx_tmo = 16'd20;
      rx_full = 1; stop_det = 1; step(); stop_det = 0;
      chk("R8", "busy rec", status, 4);
      chk("R8", "no hold", scl_hold, 0);
      match(1'b0);
      chk("R8", "write nacked", force_nack, 1);
      chk("R8", "stays", status, 4);
      match(1'b1);
      chk("R8", "read to transmit", status, 2);
      mst_nack = 1; step(); mst_nack = 0;
      rx_full = 0; match(1'b0);
      rx_full = 1; stop_det = 1; step(); stop_det = 0;
      rx_full = 0; step();
      chk("R8", "not full to standby", status, 1);
      chk("R8", "no flush", rx_flush, 0);
      match(1'b0);
      rx_tmo = 16'd3;
      rx_full = 1; stop_det = 1; step(); stop_det = 0;
      chk("R12", "drain loaded", tmo_now, 3);
      step(); step(); step(); step();
      chk("R8", "expiry standby", status, 1);
      chk("R8", "expiry flush", rx_flush, 1);
      chk("R8", "recover 2", recover, 2);
      chk("R8", "no nack", force_nack, 0);
   endtask

   task automatic t_transmit();
      do_reset(); go_idle();
      match(1'b1);
      chk("R4", "transmit", status, 2);
      chk("R4", "irq en", tx_irq_en, 1);
      mst_nack = 1; step(); mst_nack = 0;
      chk("R9", "standby", status, 1);
      chk("R9", "tx flush", tx_flush, 1);
      chk("R9", "irq cleared", tx_irq_en, 0);
      tx_empty = 1; match(1'b1);
      chk("R4", "empty stalls", status, 6);
      chk("R4", "hold", scl_hold, 1);
      chk("R12", "tx loaded", tmo_now, 2);
      step(); step();
      chk("R11", "still stalled", status, 6);
      step();
      chk("R11", "back to transmit", status, 2);
      chk("R11", "dup", dup_req, 1);
      chk("R11", "recover 4", recover, 4);
      chk("R11", "hold released", scl_hold, 0);
      byte_req = 1; step(); byte_req = 0;
      chk("R10", "stall again", status, 6);
      chk("R10", "hold", scl_hold, 1);
      tx_empty = 0; step();
      chk("R10", "refilled", status, 2);
      chk("R10", "recover 0", recover, 0);
      chk("R10", "no dup", dup_req, 0);
   endtask

   initial begin
      t_reset();
      t_enable();
      t_write_match();
      t_receive_end();
      t_rx_stall();
      t_drain();
      t_transmit();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule